// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the write-command interpreter of a parallel NOR flash, written as a synchronous model. It watches host write cycles, each with an address, a 16-bit data word and a one-cycle write strobe. It recognises command sequences that must open with unlock cycles, and from them it launches program and erase operations. A cycle counter stands in for the array timing, so every program or erase occupies the block for a fixed number of clock cycles set by a parameter.

The host learns what the block is doing from four outputs. `busy` is high while an internal operation runs. `suspended` is high while an erase is parked and the array may be read. `launch` and `done` are one-cycle pulses that mark the start and the end of an operation. The most recently launched operation is reported on `act_kind`, `act_addr` and `act_data`.

A sector or block erase can be suspended. While it is suspended, the host may program any word outside the parked region, and a later single write resumes the erase. The write-protect input guards two 4 KW boot blocks and disables chip erase. By default these are the lowest two blocks, where address bits 20..13 are all zero. Reset returns everything to the idle read state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Command cycles are matched on the low 11 address bits and the low 8 data bits. A program is the sequence AAh@555h, 55h@2AAh, A0h@555h, followed by a fourth write carrying the target address and data word. The fourth write makes `launch` pulse the next cycle, with `act_kind`=1, `act_addr` and `act_data` taken from that write.
- R2: A sector erase is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 50h at the target address. It launches with `act_kind`=2 and `act_addr` set to that address. The sector is selected by address bits 20..11.
- R3: The same six-write sequence ending in 30h launches a block erase with `act_kind`=3. The block is selected by bits 20..15, or by bits 20..12 inside the 32 KW boot region.
- R4: The six-write sequence ending in 10h launches a chip erase with `act_kind`=4, but only when that last write is at 555h. At any other address it does nothing.
- R5: `busy` rises in the cycle of `launch` and stays high for exactly PROG_CYC, ERASE_CYC or CHIP_CYC cycles, depending on the operation. `done` pulses for one cycle in the cycle `busy` falls.
- R6: A write that does not match the next expected cycle of a sequence returns the decoder to idle, with no launch. The next complete sequence still works.
- R7: Every write made while `busy` is high is ignored. This covers complete command sequences, and B0h during a program or a chip erase.
- R8: A write of B0h, at any address, during a sector or block erase keeps `busy` high for exactly SUSP_CYC more cycles. After that `suspended` is 1 and `busy` is 0. While parked, the erase makes no progress and produces no `done`.
- R9: A write of 30h at any address while suspended resumes the erase. Its total busy time, excluding the suspend wait, still equals ERASE_CYC. A 30h while idle does nothing.
- R10: While suspended, a program outside the parked region launches, runs PROG_CYC busy cycles and returns to the suspended state. A program inside the parked region is dropped, and so are all erase commands.
- R11: With `wp_n` low, a program, sector erase or block erase targeting the protected boot blocks is dropped, and a chip erase is always dropped. With `wp_n` high, all of these are accepted.
- R12: A low `rst_n` immediately forces `busy`=0, `suspended`=0, `act_kind`=0 and clears any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 21 | Write address |
| wr_data | input | 16 | Write data |
| wp_n | input | 1 | Write protect, active low |
| busy | output | 1 | Internal operation in progress |
| suspended | output | 1 | Erase parked, array readable |
| launch | output | 1 | Operation started (one-cycle pulse) |
| done | output | 1 | Operation finished (one-cycle pulse) |
| act_kind | output | 3 | Last launched operation: 0 none, 1 program, 2 sector, 3 block, 4 chip |
| act_addr | output | 21 | Address of the last launched operation |
| act_data | output | 16 | Data word of the last launched program |

## Verification
Random command streams mix the four operation kinds with random targets and random write-protect levels. In some of them one unlock cycle is corrupted, which tells a true abort apart from a late or spurious launch. It also tells a protected target apart from a free one next to it. Directed cases cover the narrower behaviour:
- a chip erase ending away from 555h;
- full sequences and B0h written while busy;
- a suspend, followed by programs inside and outside the parked sector, an erase attempt and a resume, where the total busy time shows that the erase progress was frozen rather than restarted;
- reset in the middle of an operation and in the middle of a sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_SECT   = 3'd2,
      OP_BLK    = 3'd3,
      OP_CHIP   = 3'd4,
      OP_SUSP   = 3'd5,
      OP_RESUME = 3'd6
   } op_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_UL1, SQ_UL2, SQ_PGM, SQ_ERS, SQ_UL4, SQ_UL5
   } seq_e;

   typedef enum logic [2:0] {
      EN_IDLE, EN_BUSY, EN_SWAIT, EN_SUSP, EN_NEST
   } eng_e;

   localparam logic [7:0] CODE_KEY_A  = 8'hAA;
   localparam logic [7:0] CODE_KEY_B  = 8'h55;
   localparam logic [7:0] CODE_PGM    = 8'hA0;
   localparam logic [7:0] CODE_ERS    = 8'h80;
   localparam logic [7:0] CODE_SECT   = 8'h50;
   localparam logic [7:0] CODE_BLK    = 8'h30;
   localparam logic [7:0] CODE_CHIP   = 8'h10;
   localparam logic [7:0] CODE_SUSP   = 8'hB0;
   localparam logic [7:0] CODE_RESUME = 8'h30;

endpackage

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
   import flash_cmd_pkg::*;
#(
   parameter int CMD_ADDR_W = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  logic [CMD_ADDR_W-1:0] wr_lo,
   input  logic [7:0]            wr_code,
   output logic                  req_valid,
   output op_e                   req_kind
);

   localparam logic [CMD_ADDR_W-1:0] ADR_KEY_A = CMD_ADDR_W'(12'h555);
   localparam logic [CMD_ADDR_W-1:0] ADR_KEY_B = CMD_ADDR_W'(12'h2AA);

   initial begin
      cmd_addr_w_chk : assert (CMD_ADDR_W >= 11)
         else $error("CMD_ADDR_W too narrow for unlock addresses");
   end

   seq_e pos, nxt;
   logic at_a, at_b;

   assign at_a = (wr_lo == ADR_KEY_A);
   assign at_b = (wr_lo == ADR_KEY_B);

   always_comb begin
      nxt       = pos;
      req_valid = 1'b0;
      req_kind  = OP_NONE;
      if (wr_en) begin
         unique case (pos)
            SQ_IDLE: begin
               if (at_a && wr_code == CODE_KEY_A) nxt = SQ_UL1;
               else if (wr_code == CODE_SUSP) begin
                  req_valid = 1'b1;
                  req_kind  = OP_SUSP;
               end else if (wr_code == CODE_RESUME) begin
                  req_valid = 1'b1;
                  req_kind  = OP_RESUME;
               end
            end
            SQ_UL1: nxt = (at_b && wr_code == CODE_KEY_B) ? SQ_UL2 : SQ_IDLE;
            SQ_UL2: begin
               if (at_a && wr_code == CODE_PGM)      nxt = SQ_PGM;
               else if (at_a && wr_code == CODE_ERS) nxt = SQ_ERS;
               else                                   nxt = SQ_IDLE;
            end
            SQ_PGM: begin
               nxt       = SQ_IDLE;
               req_valid = 1'b1;
               req_kind  = OP_PROG;
            end
            SQ_ERS: nxt = (at_a && wr_code == CODE_KEY_A) ? SQ_UL4 : SQ_IDLE;
            SQ_UL4: nxt = (at_b && wr_code == CODE_KEY_B) ? SQ_UL5 : SQ_IDLE;
            SQ_UL5: begin
               nxt = SQ_IDLE;
               if (wr_code == CODE_SECT) begin
                  req_valid = 1'b1;
                  req_kind  = OP_SECT;
               end else if (wr_code == CODE_BLK) begin
                  req_valid = 1'b1;
                  req_kind  = OP_BLK;
               end else if (wr_code == CODE_CHIP && at_a) begin
                  req_valid = 1'b1;
                  req_kind  = OP_CHIP;
               end
            end
            default: nxt = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pos <= SQ_IDLE;
      else if (clr) pos <= SQ_IDLE;
      else          pos <= nxt;
   end

   // R6
   seq_step_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (pos != $past(pos)) |-> ($past(wr_en) || $past(clr)));

   // R7
   seq_clear_chk : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pos == SQ_IDLE));

endmodule

// File: rtl/flash_wp_filter.sv
module flash_wp_filter
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W        = 21,
   parameter int SECT_LSB      = 11,
   parameter int SMALL_BLK_LSB = 12,
   parameter int BLK_LSB       = 15,
   parameter bit BOOT_TOP      = 1'b0
) (
   input  op_e                        req_kind,
   input  logic [ADDR_W-SECT_LSB-1:0] req_hi,
   input  logic                       wp_n,
   input  op_e                        sus_kind,
   input  logic [ADDR_W-SECT_LSB-1:0] sus_hi,
   output logic                       blocked,
   output logic                       same_region
);

   localparam int HI_W      = ADDR_W - SECT_LSB;
   localparam int BLK_OFS   = BLK_LSB - SECT_LSB;
   localparam int SMALL_OFS = SMALL_BLK_LSB - SECT_LSB;
   localparam int PROT_OFS  = SMALL_OFS + 1;

   initial begin
      field_order_chk : assert (SECT_LSB < SMALL_BLK_LSB && SMALL_BLK_LSB < BLK_LSB
                                && BLK_LSB < ADDR_W)
         else $error("address field boundaries out of order");
   end

   logic in_prot, sus_boot, targets_array;

   generate
      if (BOOT_TOP) begin : g_top_boot
         assign in_prot  = &req_hi[HI_W-1:PROT_OFS];
         assign sus_boot = &sus_hi[HI_W-1:BLK_OFS];
      end else begin : g_bot_boot
         assign in_prot  = ~|req_hi[HI_W-1:PROT_OFS];
         assign sus_boot = ~|sus_hi[HI_W-1:BLK_OFS];
      end
   endgenerate

   assign targets_array = (req_kind == OP_PROG) || (req_kind == OP_SECT) ||
                          (req_kind == OP_BLK);
   assign blocked = !wp_n && ((req_kind == OP_CHIP) || (targets_array && in_prot));

   always_comb begin
      unique case (sus_kind)
         OP_SECT: same_region = (req_hi == sus_hi);
         OP_BLK:  same_region = sus_boot
                     ? (req_hi[HI_W-1:SMALL_OFS] == sus_hi[HI_W-1:SMALL_OFS])
                     : (req_hi[HI_W-1:BLK_OFS]   == sus_hi[HI_W-1:BLK_OFS]);
         default: same_region = 1'b0;
      endcase
   end

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 21,
   parameter int DATA_W    = 16,
   parameter int SECT_LSB  = 11,
   parameter int PROG_CYC  = 8,
   parameter int ERASE_CYC = 64,
   parameter int CHIP_CYC  = 128,
   parameter int SUSP_CYC  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  op_e                        req_kind,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_data,
   input  logic                       blocked,
   input  logic                       same_region,
   output logic                       busy,
   output logic                       suspended,
   output logic                       launch,
   output logic                       done,
   output op_e                        act_kind,
   output logic [ADDR_W-1:0]          act_addr,
   output logic [DATA_W-1:0]          act_data,
   output op_e                        ers_kind,
   output logic [ADDR_W-SECT_LSB-1:0] ers_hi
);

   localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int MAX_B = (CHIP_CYC > SUSP_CYC) ? CHIP_CYC : SUSP_CYC;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = $clog2(MAX_C + 1);

   initial begin
      cycle_cnt_chk : assert (PROG_CYC >= 1 && ERASE_CYC >= 1 && CHIP_CYC >= 1 && SUSP_CYC >= 1)
         else $error("operation lengths must be at least one cycle");
   end

   function automatic logic [CNT_W-1:0] run_len(op_e k);
      unique case (k)
         OP_PROG: return CNT_W'(PROG_CYC - 1);
         OP_CHIP: return CNT_W'(CHIP_CYC - 1);
         default: return CNT_W'(ERASE_CYC - 1);
      endcase
   endfunction

   eng_e             st;
   logic [CNT_W-1:0] main_cnt, aux_cnt;
   logic             is_op, can_susp;

   assign is_op    = (req_kind == OP_PROG) || (req_kind == OP_SECT) ||
                     (req_kind == OP_BLK)  || (req_kind == OP_CHIP);
   assign can_susp = (ers_kind == OP_SECT) || (ers_kind == OP_BLK);
   assign busy      = (st == EN_BUSY) || (st == EN_SWAIT) || (st == EN_NEST);
   assign suspended = (st == EN_SUSP) || (st == EN_NEST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= EN_IDLE;
         main_cnt <= '0;
         aux_cnt  <= '0;
         launch   <= 1'b0;
         done     <= 1'b0;
         act_kind <= OP_NONE;
         act_addr <= '0;
         act_data <= '0;
         ers_kind <= OP_NONE;
         ers_hi   <= '0;
      end else begin
         launch <= 1'b0;
         done   <= 1'b0;
         unique case (st)
            EN_IDLE: begin
               if (req_valid && is_op && !blocked) begin
                  st       <= EN_BUSY;
                  launch   <= 1'b1;
                  main_cnt <= run_len(req_kind);
                  act_kind <= req_kind;
                  act_addr <= req_addr;
                  act_data <= req_data;
                  ers_kind <= req_kind;
                  ers_hi   <= req_addr[ADDR_W-1:SECT_LSB];
               end
            end
            EN_BUSY: begin
               if (main_cnt == '0) begin
                  st   <= EN_IDLE;
                  done <= 1'b1;
               end else begin
                  main_cnt <= main_cnt - 1'b1;
                  if (req_valid && req_kind == OP_SUSP && can_susp) begin
                     st      <= EN_SWAIT;
                     aux_cnt <= CNT_W'(SUSP_CYC - 1);
                  end
               end
            end
            EN_SWAIT: begin
               if (aux_cnt == '0) st <= EN_SUSP;
               else               aux_cnt <= aux_cnt - 1'b1;
            end
            EN_SUSP: begin
               if (req_valid && req_kind == OP_RESUME) begin
                  st <= EN_BUSY;
               end else if (req_valid && req_kind == OP_PROG && !blocked && !same_region) begin
                  st       <= EN_NEST;
                  launch   <= 1'b1;
                  aux_cnt  <= CNT_W'(PROG_CYC - 1);
                  act_kind <= req_kind;
                  act_addr <= req_addr;
                  act_data <= req_data;
               end
            end
            EN_NEST: begin
               if (aux_cnt == '0) begin
                  st   <= EN_SUSP;
                  done <= 1'b1;
               end else begin
                  aux_cnt <= aux_cnt - 1'b1;
               end
            end
            default: st <= EN_IDLE;
         endcase
      end
   end

   // R5
   launch_busy_chk : assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> busy);

   // R5
   done_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   busy_rise_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !$past(suspended)) |-> launch);

   // R8
   frozen_cnt_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (st != EN_BUSY && st != EN_IDLE && $past(st) != EN_BUSY && $past(st) != EN_IDLE)
      |-> $stable(main_cnt));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W        = 21,
   parameter int DATA_W        = 16,
   parameter int CMD_ADDR_W    = 11,
   parameter int SECT_LSB      = 11,
   parameter int SMALL_BLK_LSB = 12,
   parameter int BLK_LSB       = 15,
   parameter bit BOOT_TOP      = 1'b0,
   parameter int PROG_CYC      = 8,
   parameter int ERASE_CYC     = 64,
   parameter int CHIP_CYC      = 128,
   parameter int SUSP_CYC      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wp_n,
   output logic              busy,
   output logic              suspended,
   output logic              launch,
   output logic              done,
   output logic [2:0]        act_kind,
   output logic [ADDR_W-1:0] act_addr,
   output logic [DATA_W-1:0] act_data
);

   localparam int HI_W = ADDR_W - SECT_LSB;

   initial begin
      widths_chk : assert (DATA_W >= 8 && CMD_ADDR_W <= ADDR_W)
         else $error("data or command address width invalid");
   end

   logic            req_valid, blocked, same_region;
   op_e             req_kind, ers_kind, act_kind_e;
   logic [HI_W-1:0] ers_hi;

   flash_unlock_seq #(.CMD_ADDR_W(CMD_ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (busy),
      .wr_en     (wr_en),
      .wr_lo     (wr_addr[CMD_ADDR_W-1:0]),
      .wr_code   (wr_data[7:0]),
      .req_valid (req_valid),
      .req_kind  (req_kind)
   );

   flash_wp_filter #(
      .ADDR_W        (ADDR_W),
      .SECT_LSB      (SECT_LSB),
      .SMALL_BLK_LSB (SMALL_BLK_LSB),
      .BLK_LSB       (BLK_LSB),
      .BOOT_TOP      (BOOT_TOP)
   ) u_filt (
      .req_kind    (req_kind),
      .req_hi      (wr_addr[ADDR_W-1:SECT_LSB]),
      .wp_n        (wp_n),
      .sus_kind    (ers_kind),
      .sus_hi      (ers_hi),
      .blocked     (blocked),
      .same_region (same_region)
   );

   flash_op_engine #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SECT_LSB  (SECT_LSB),
      .PROG_CYC  (PROG_CYC),
      .ERASE_CYC (ERASE_CYC),
      .CHIP_CYC  (CHIP_CYC),
      .SUSP_CYC  (SUSP_CYC)
   ) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_kind    (req_kind),
      .req_addr    (wr_addr),
      .req_data    (wr_data),
      .blocked     (blocked),
      .same_region (same_region),
      .busy        (busy),
      .suspended   (suspended),
      .launch      (launch),
      .done        (done),
      .act_kind    (act_kind_e),
      .act_addr    (act_addr),
      .act_data    (act_data),
      .ers_kind    (ers_kind),
      .ers_hi      (ers_hi)
   );

   assign act_kind = act_kind_e;

   // R11
   chip_wp_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (launch && act_kind_e == OP_CHIP) |-> $past(wp_n));

   // R10
   nest_prog_only_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (launch && $past(suspended)) |-> (act_kind_e == OP_PROG));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

   localparam int PROG_CYC  = 6;
   localparam int ERASE_CYC = 20;
   localparam int CHIP_CYC  = 30;
   localparam int SUSP_CYC  = 3;

   logic        clk, rst_n, wr_en, wp_n;
   logic [20:0] wr_addr;
   logic [15:0] wr_data;
   logic        busy, suspended, launch, done;
   logic [2:0]  act_kind;
   logic [20:0] act_addr;
   logic [15:0] act_data;

   int checks = 0;
   int failures = 0;
   int launch_cnt = 0, done_cnt = 0, busy_cyc = 0, susp_cyc = 0;

   flash_cmd_decoder #(
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
      .CHIP_CYC(CHIP_CYC), .SUSP_CYC(SUSP_CYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wp_n(wp_n), .busy(busy), .suspended(suspended), .launch(launch), .done(done),
      .act_kind(act_kind), .act_addr(act_addr), .act_data(act_data)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   always @(posedge clk) begin
      #2;
      if (launch)    launch_cnt++;
      if (done)      done_cnt++;
      if (busy)      busy_cyc++;
      if (suspended) susp_cyc++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int dur(input int kind);
      if (kind == 1) return PROG_CYC;
      if (kind == 4) return CHIP_CYC;
      return ERASE_CYC;
   endfunction

   function automatic bit expect_go(input int kind, input logic [20:0] a,
                                    input bit w, input int bad);
      if (bad >= 0) return 1'b0;
      if (!w && (kind == 4 || a[20:13] == 8'd0)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic wr(input logic [20:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send(input int kind, input logic [20:0] a, input logic [15:0] d,
                       input int bad);
      logic [20:0] aa [6];
      logic [15:0] dd [6];
      int n;
      aa[0] = 21'h555; dd[0] = 16'h00AA;
      aa[1] = 21'h2AA; dd[1] = 16'h0055;
      if (kind == 1) begin
         aa[2] = 21'h555; dd[2] = 16'h00A0;
         aa[3] = a;       dd[3] = d;
         n = 4;
      end else begin
         aa[2] = 21'h555; dd[2] = 16'h0080;
         aa[3] = 21'h555; dd[3] = 16'h00AA;
         aa[4] = 21'h2AA; dd[4] = 16'h0055;
         aa[5] = a;
         dd[5] = (kind == 2) ? 16'h0050 : (kind == 3) ? 16'h0030 : 16'h0010;
         n = 6;
      end
      for (int i = 0; i < n; i++) wr(aa[i], (i == bad) ? 16'h0000 : dd[i]);
   endtask

   task automatic wait_idle();
      for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
   endtask

   task automatic busy_len(output int n);
      n = 0;
      for (int g = 0; g < 1000 && busy; g++) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int n, l0, d0, b0, s0;
      void'($urandom(32'd4711));
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wp_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R12 reset busy", busy, 0);
      chk("R12 reset suspended", suspended, 0);
      chk("R12 reset kind", act_kind, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 program
      send(1, 21'h1A_2345, 16'hC3A5, -1);
      chk("R1 launch", launch, 1);
      chk("R1 kind", act_kind, 1);
      chk("R1 addr", act_addr, 21'h1A_2345);
      chk("R1 data", act_data, 16'hC3A5);
      busy_len(n);
      chk("R5 program busy length", n, PROG_CYC);
      chk("R5 done pulse", done, 1);

      // R2 sector erase
      send(2, 21'h0C_4800, 16'h0, -1);
      chk("R2 launch", launch, 1);
      chk("R2 kind", act_kind, 2);
      chk("R2 addr", act_addr, 21'h0C_4800);
      busy_len(n);
      chk("R5 erase busy length", n, ERASE_CYC);

      // R3 block erase
      send(3, 21'h12_3456, 16'h0, -1);
      chk("R3 kind", act_kind, 3);
      chk("R3 addr", act_addr, 21'h12_3456);
      wait_idle();

      // R4 chip erase
      send(4, 21'h555, 16'h0, -1);
      chk("R4 kind", act_kind, 4);
      busy_len(n);
      chk("R4 chip busy length", n, CHIP_CYC);
      l0 = launch_cnt;
      send(4, 21'h556, 16'h0, -1);
      repeat (2) @(negedge clk);
      chk("R4 wrong address no launch", launch_cnt, l0);
      chk("R4 wrong address idle", busy, 0);

      // R6 broken sequence then a clean one
      l0 = launch_cnt;
      wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0012);
      wr(21'h555, 16'h00A0); wr(21'h3000, 16'h00AA);
      chk("R6 abort no launch", launch_cnt, l0);
      wr(21'h0, 16'h0);
      send(1, 21'h3000, 16'h0101, -1);
      chk("R6 clean sequence launches", launch_cnt, l0 + 1);
      wait_idle();

      // R7 full program during erase
      l0 = launch_cnt; b0 = busy_cyc;
      send(2, 21'h08_0000, 16'h0, -1);
      send(1, 21'h09_0000, 16'h5555, -1);
      wait_idle();
      chk("R7 sequence during busy ignored", launch_cnt, l0 + 1);
      chk("R7 erase length unchanged", busy_cyc - b0, ERASE_CYC);
      chk("R7 act kind kept", act_kind, 2);

      // R7 suspend during program and chip erase
      s0 = susp_cyc; b0 = busy_cyc;
      send(1, 21'h09_0000, 16'h7777, -1);
      wr(21'h0, 16'h00B0);
      wait_idle();
      send(4, 21'h555, 16'h0, -1);
      wr(21'h0, 16'h00B0);
      wait_idle();
      chk("R7 no suspend of program or chip", susp_cyc, s0);
      chk("R7 lengths with B0", busy_cyc - b0, PROG_CYC + CHIP_CYC);

      // R9 resume when idle
      l0 = launch_cnt;
      wr(21'h0, 16'h0030);
      @(negedge clk);
      chk("R9 idle resume ignored", launch_cnt, l0);
      chk("R9 idle resume busy", busy, 0);

      // R8 R9 R10 suspend flow
      l0 = launch_cnt; d0 = done_cnt; b0 = busy_cyc;
      send(2, 21'h04_0000, 16'h0, -1);
      repeat (3) @(negedge clk);
      wr(21'h0, 16'h00B0);
      chk("R8 still busy after suspend", busy, 1);
      busy_len(n);
      chk("R8 suspend wait length", n, SUSP_CYC);
      chk("R8 suspended", suspended, 1);
      repeat (8) @(negedge clk);
      chk("R8 parked no done", done_cnt, d0);
      chk("R8 parked still suspended", suspended, 1);
      send(1, 21'h04_0010, 16'h1234, -1);
      @(negedge clk);
      chk("R10 program in parked sector dropped", launch_cnt, l0 + 1);
      send(3, 21'h08_0000, 16'h0, -1);
      @(negedge clk);
      chk("R10 erase while suspended dropped", launch_cnt, l0 + 1);
      chk("R10 block erase did not resume", suspended, 1);
      send(1, 21'h08_0020, 16'hBEEF, -1);
      chk("R10 outside program launches", launch, 1);
      chk("R10 nested data", act_data, 16'hBEEF);
      busy_len(n);
      chk("R10 nested length", n, PROG_CYC);
      chk("R10 back to suspended", suspended, 1);
      wr(21'h01_1234, 16'h0030);
      chk("R9 resumed busy", busy, 1);
      chk("R9 resumed not suspended", suspended, 0);
      wait_idle();
      chk("R9 done count", done_cnt, d0 + 2);
      chk("R9 total busy", busy_cyc - b0, ERASE_CYC + SUSP_CYC + PROG_CYC);

      // R11 write protect directed
      wp_n = 1'b0; l0 = launch_cnt;
      send(1, 21'h00_1F00, 16'h1, -1);
      send(2, 21'h00_0800, 16'h0, -1);
      send(4, 21'h555, 16'h0, -1);
      @(negedge clk);
      chk("R11 protected dropped", launch_cnt, l0);
      send(1, 21'h00_2000, 16'h2, -1);
      chk("R11 unprotected accepted", launch, 1);
      wait_idle();
      wp_n = 1'b1;
      send(1, 21'h00_1F00, 16'h3, -1);
      chk("R11 protect released", launch, 1);
      wait_idle();

      // R12 reset mid operation and mid sequence
      send(4, 21'h555, 16'h0, -1);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R12 mid-op busy cleared", busy, 0);
      chk("R12 mid-op kind cleared", act_kind, 0);
      @(negedge clk); rst_n = 1'b1;
      wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055);
      @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      l0 = launch_cnt;
      wr(21'h555, 16'h00A0); wr(21'h3000, 16'h0005);
      @(negedge clk);
      chk("R12 sequence cleared", launch_cnt, l0);

      // random mix: R1 R2 R3 R4 R5 R6 R11
      for (int i = 0; i < 40; i++) begin
         int kind, bad;
         logic [20:0] a;
         logic [15:0] d;
         bit w, go;
         kind = 1 + int'($urandom % 4);
         a = ($urandom % 4 == 0) ? 21'($urandom % 32'h2000) : 21'($urandom);
         if (kind == 4) a = 21'h555;
         d = 16'($urandom);
         w = ($urandom % 3) != 0;
         bad = ($urandom % 3 == 0) ? int'($urandom % ((kind == 1) ? 3 : 6)) : -1;
         go = expect_go(kind, a, w, bad);
         wp_n = w;
         wr(21'h0, 16'h0);
         b0 = busy_cyc;
         send(kind, a, d, bad);
         chk("R6 R11 random launch", launch, go);
         if (go) begin
            chk("R1 R2 R3 R4 random kind", act_kind, kind);
            chk("R1 random addr", act_addr, a);
            wait_idle();
            chk("R5 random length", busy_cyc - b0, dur(kind));
         end else begin
            chk("R6 random idle", busy, 0);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule